// File: doc/BRIEF.md
# Signaling Channel Change Detector

This block watches the control bytes (command/indication or signaling values) that arrive on a framed, timeslot-based upstream link. Each frame has a number of timeslots; every even slot carries a message channel and the odd slot after it carries that channel's control byte. The block keeps one stored upstream value per control channel. Each time a control slot arrives, the incoming byte is compared with the stored one. When they differ, the stored value is replaced and the channel number is appended to a small pending-change queue. A non-empty queue raises the interrupt line to the host.

The host reads the stored upstream value of any channel through a combinational read port. It drains the change queue one entry per pop. It also writes a downstream control byte per channel. A written byte is staged and takes effect at the next frame start, and from then on it is driven on that channel's odd slot in every frame. For one frame after reset the block learns the incoming values without reporting them, so the reset contents never produce a burst of false changes. Serialization and the message channel belong to neighbouring logic.

Top module: `sigchg_detector`

## Requirements
- R1: Only cycles with `slot_valid`=1 and an odd `slot_num` (bit 0 = 1) are control slots; their channel index is `slot_num[4:1]`. Even slots and cycles without `slot_valid` never change stored values, the queue or the interrupt.
- R2: After reset every stored upstream value and every downstream value is 0xFF, `irq`=0 and `ovf`=0.
- R3: A frame start is a cycle with `slot_valid`=1 and `slot_num`=0. Until the second frame start after reset, control slots update stored values but queue no change.
- R4: Once reporting is enabled, a control byte that differs from the stored value replaces it at that clock edge and queues its channel index. A byte equal to the stored value does nothing.
- R5: `irq` is 1 exactly while the queue holds an entry, and `chg_chan` then shows the oldest entry. `chg_pop` removes one entry, is ignored on an empty queue, and may coincide with a push.
- R6: A change that arrives while the queue holds 8 entries and no pop is given is dropped from the queue. It sets `ovf`, which stays 1 until reset, and the stored value is still updated.
- R7: `up_rd_data` combinationally returns the stored upstream value of channel `up_rd_chan`.
- R8: A downstream write (`dn_wr_en`, `dn_wr_chan`, `dn_wr_data`) is staged. It becomes the driven value at the clock edge of the next frame-start cycle. A write made during a frame-start cycle waits for the following frame start.
- R9: `tx_en` is 1 on control slots. `tx_byte` then carries the active downstream value of the slot's channel, and it is 0xFF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | A timeslot is present this cycle |
| slot_num | input | 5 | Timeslot number within the frame |
| rx_byte | input | 8 | Received byte of the current timeslot |
| tx_en | output | 1 | Block drives the current timeslot |
| tx_byte | output | 8 | Downstream byte for the current timeslot |
| up_rd_chan | input | 4 | Host read channel |
| up_rd_data | output | 8 | Stored upstream value of the read channel |
| dn_wr_en | input | 1 | Host downstream write strobe |
| dn_wr_chan | input | 4 | Host downstream write channel |
| dn_wr_data | input | 8 | Host downstream write value |
| irq | output | 1 | Change queue not empty |
| chg_chan | output | 4 | Oldest queued changed channel |
| chg_pop | input | 1 | Remove oldest queue entry |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The bench targets the learning frame after reset. A design that arms too early reports every channel as changed, and one that stops learning leaves stale values to be reported later. It repeats identical frames, where a design that compares badly fires on unchanged bytes. It also drives a frame in which all sixteen channels change with no pops, which catches a queue that wraps over its oldest entries or an overflow that forgets the memory update. It times downstream writes both mid-frame and on the frame-start cycle, where a design without staging would switch the driven byte in the middle of a frame.

// File: rtl/sigchg_pkg.sv
package sigchg_pkg;
    localparam int SLOTS_DEF  = 32;
    localparam int DW_DEF     = 8;
    localparam int QDEPTH_DEF = 8;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/sigchg_upmem.sv
module sigchg_upmem #(
    parameter int CH = 16,
    parameter int DW = 8,
    localparam int CW = $clog2(CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_chan,
    input  logic [DW-1:0] rx_byte,
    input  logic [CW-1:0] rd_chan,
    output logic          differs,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [CH-1:0][DW-1:0] mem;
    } state_t;

    localparam state_t RST = '{mem: {CH{DW'(sigchg_pkg::IDLE_BYTE)}}};

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        differs = (st_q.mem[wr_chan] != rx_byte);
        if (wr_en && differs) begin
            st_d.mem[wr_chan] = rx_byte;
        end
        rd_data = st_q.mem[rd_chan];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sigchg_queue.sv
module sigchg_queue #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [CW-1:0] push_data,
    input  logic          pop,
    output logic          nonempty,
    output logic [CW-1:0] head,
    output logic          overflow
);
    localparam logic [NW-1:0] FULL = NW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] ent;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [NW-1:0]            cnt;
        logic                     ovf;
    } state_t;

    state_t st_d, st_q;
    logic   pop_ok, push_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && (st_q.cnt != '0);
        push_ok = push && ((st_q.cnt != FULL) || pop_ok);
        if (push_ok) begin
            st_d.ent[st_q.wr] = push_data;
            st_d.wr           = nxt(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = nxt(st_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push && !push_ok) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nonempty = (st_q.cnt != '0);
    assign head     = st_q.ent[st_q.rd];
    assign overflow = st_q.ovf;
endmodule

// File: rtl/sigchg_dnmem.sv
module sigchg_dnmem #(
    parameter int CH = 16,
    parameter int DW = 8,
    localparam int CW = $clog2(CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_chan,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_start,
    input  logic [CW-1:0] rd_chan,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [CH-1:0][DW-1:0] staged;
        logic [CH-1:0][DW-1:0] active;
    } state_t;

    localparam state_t RST = '{staged: {CH{DW'(sigchg_pkg::IDLE_BYTE)}},
                               active: {CH{DW'(sigchg_pkg::IDLE_BYTE)}}};

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.active = st_q.staged;
        end
        if (wr_en) begin
            st_d.staged[wr_chan] = wr_data;
        end
        rd_data = st_q.active[rd_chan];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sigchg_detector.sv
module sigchg_detector #(
    parameter int SLOTS  = sigchg_pkg::SLOTS_DEF,
    parameter int DW     = sigchg_pkg::DW_DEF,
    parameter int QDEPTH = sigchg_pkg::QDEPTH_DEF,
    localparam int CH    = SLOTS / 2,
    localparam int SW    = $clog2(SLOTS),
    localparam int CW    = $clog2(CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_valid,
    input  logic [SW-1:0] slot_num,
    input  logic [DW-1:0] rx_byte,
    output logic          tx_en,
    output logic [DW-1:0] tx_byte,
    input  logic [CW-1:0] up_rd_chan,
    output logic [DW-1:0] up_rd_data,
    input  logic          dn_wr_en,
    input  logic [CW-1:0] dn_wr_chan,
    input  logic [DW-1:0] dn_wr_data,
    output logic          irq,
    output logic [CW-1:0] chg_chan,
    input  logic          chg_pop,
    output logic          ovf
);
    typedef struct packed {
        logic seen_start;
        logic armed;
    } arm_t;

    arm_t          arm_d, arm_q;
    logic          frame_start, ctrl_slot, differs, push;
    logic [CW-1:0] ctrl_chan;
    logic [DW-1:0] act_byte;

    assign frame_start = slot_valid && (slot_num == '0);
    assign ctrl_slot   = slot_valid && slot_num[0];
    assign ctrl_chan   = slot_num[SW-1:1];

    always_comb begin
        arm_d = arm_q;
        if (frame_start) begin
            arm_d.seen_start = 1'b1;
            arm_d.armed      = arm_q.armed | arm_q.seen_start;
        end
        push = ctrl_slot && differs && arm_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= arm_d;
    end

    sigchg_upmem #(.CH(CH), .DW(DW)) u_upmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_slot),
        .wr_chan (ctrl_chan),
        .rx_byte (rx_byte),
        .rd_chan (up_rd_chan),
        .differs (differs),
        .rd_data (up_rd_data)
    );

    sigchg_queue #(.DEPTH(QDEPTH), .CW(CW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (ctrl_chan),
        .pop       (chg_pop),
        .nonempty  (irq),
        .head      (chg_chan),
        .overflow  (ovf)
    );

    sigchg_dnmem #(.CH(CH), .DW(DW)) u_dnmem (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (dn_wr_en),
        .wr_chan     (dn_wr_chan),
        .wr_data     (dn_wr_data),
        .frame_start (frame_start),
        .rd_chan     (ctrl_chan),
        .rd_data     (act_byte)
    );

    assign tx_en   = ctrl_slot;
    assign tx_byte = ctrl_slot ? act_byte : DW'(sigchg_pkg::IDLE_BYTE);
endmodule

// File: rtl/sigchg_detector_chk.sv
module sigchg_detector_chk #(
    parameter int SW = 5,
    parameter int CW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_valid,
    input logic [SW-1:0] slot_num,
    input logic [DW-1:0] rx_byte,
    input logic [CW-1:0] up_rd_chan,
    input logic [DW-1:0] up_rd_data,
    input logic          irq,
    input logic          ovf
);
    // R1 R5: with an empty queue and no control slot, no interrupt can appear
    a_r1_no_spurious_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(slot_valid && slot_num[0])) |=> !irq);

    // R4: a control byte equal to the stored value on an empty queue raises nothing
    a_r4_equal_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && slot_valid && slot_num[0] && (up_rd_chan == slot_num[SW-1:1])
         && (rx_byte == up_rd_data)) |=> !irq);

    // R4 R7: the stored value of a control channel follows its received byte
    a_r7_store_follows_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_num[0] && (up_rd_chan == slot_num[SW-1:1]))
        |=> ((up_rd_chan != $past(up_rd_chan)) || (up_rd_data == $past(rx_byte))));

    // R6: overflow is sticky
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R6: overflow only rises while the queue already holds entries
    a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(irq));
endmodule

bind sigchg_detector sigchg_detector_chk #(.SW(SW), .CW(CW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (slot_valid),
    .slot_num   (slot_num),
    .rx_byte    (rx_byte),
    .up_rd_chan (up_rd_chan),
    .up_rd_data (up_rd_data),
    .irq        (irq),
    .ovf        (ovf)
);

// File: tb/sigchg_detector_bench.sv
`timescale 1ns/1ps
module sigchg_detector_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       slot_valid = 0;
    logic [4:0] slot_num = 0;
    logic [7:0] rx_byte = 0;
    logic       tx_en;
    logic [7:0] tx_byte;
    logic [3:0] up_rd_chan = 0;
    logic [7:0] up_rd_data;
    logic       dn_wr_en = 0;
    logic [3:0] dn_wr_chan = 0;
    logic [7:0] dn_wr_data = 0;
    logic       irq;
    logic [3:0] chg_chan;
    logic       chg_pop = 0;
    logic       ovf;

    always #5 clk = ~clk;

    sigchg_detector u_sigchg_detector (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_num(slot_num),
        .rx_byte(rx_byte), .tx_en(tx_en), .tx_byte(tx_byte),
        .up_rd_chan(up_rd_chan), .up_rd_data(up_rd_data),
        .dn_wr_en(dn_wr_en), .dn_wr_chan(dn_wr_chan), .dn_wr_data(dn_wr_data),
        .irq(irq), .chg_chan(chg_chan), .chg_pop(chg_pop), .ovf(ovf)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_up [16];
    logic [7:0] m_stg [16];
    logic [7:0] m_act [16];
    logic [3:0] m_q [8];
    int         m_cnt;
    bit         m_ovf, m_seen, m_armed;
    logic [7:0] fr_vals [16];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_tx(input bit v, input int sn);
        if (v && (sn % 2 == 1)) return m_act[sn / 2];
        return 8'hFF;
    endfunction

    task automatic cyc(input bit v, input int sn, input logic [7:0] rx,
                       input bit wr, input int wc, input logic [7:0] wd,
                       input bit pop, input int rc);
        bit push;
        bit popok;
        int ch;
        @(negedge clk);
        slot_valid = v; slot_num = 5'(sn); rx_byte = rx;
        dn_wr_en = wr; dn_wr_chan = 4'(wc); dn_wr_data = wd;
        chg_pop = pop; up_rd_chan = 4'(rc);
        #1;
        check(irq == (m_cnt != 0), "R5 irq", irq, m_cnt != 0);
        if (m_cnt != 0) check(chg_chan == m_q[0], "R5 head", chg_chan, m_q[0]);
        check(ovf == m_ovf, "R6 ovf", ovf, m_ovf);
        check(up_rd_data == m_up[rc], "R7 read", up_rd_data, m_up[rc]);
        check(tx_en == (v && (sn % 2 == 1)), "R9 tx_en", tx_en, v && (sn % 2 == 1));
        check(tx_byte == exp_tx(v, sn), "R8 R9 tx_byte", tx_byte, exp_tx(v, sn));
        // model update
        if (v && sn == 0) for (int i = 0; i < 16; i++) m_act[i] = m_stg[i];
        if (wr) m_stg[wc] = wd;
        push = 0;
        if (v && (sn % 2 == 1)) begin
            ch = sn / 2;
            if (rx != m_up[ch]) begin
                m_up[ch] = rx;
                push = m_armed;
            end
        end
        popok = pop && (m_cnt > 0);
        if (popok) begin
            for (int i = 0; i < 7; i++) m_q[i] = m_q[i + 1];
            m_cnt--;
        end
        if (push) begin
            if (m_cnt < 8) begin m_q[m_cnt] = 4'(sn / 2); m_cnt++; end
            else m_ovf = 1;
        end
        if (v && sn == 0) begin
            if (m_seen) m_armed = 1;
            m_seen = 1;
        end
    endtask

    // rnd=0: odd slots carry fr_vals, no host activity except one write at wr_at
    task automatic run_frame(input bit rnd, input int wr_at, input int wc, input logic [7:0] wd);
        logic [7:0] rx;
        for (int s = 0; s < 32; s++) begin
            if (rnd) begin
                while ($urandom % 4 == 0)
                    cyc(0, $urandom % 32, 8'($urandom), $urandom % 5 == 0, $urandom % 16,
                        8'($urandom), $urandom % 3 == 0, $urandom % 16);
                if (s % 2 == 1) rx = ($urandom % 3 == 0) ? 8'($urandom % 4) : m_up[s / 2];
                else rx = 8'($urandom);
                cyc(1, s, rx, $urandom % 6 == 0, $urandom % 16, 8'($urandom),
                    $urandom % 3 == 0, $urandom % 16);
            end else begin
                rx = (s % 2 == 1) ? fr_vals[s / 2] : 8'($urandom);
                cyc(1, s, rx, s == wr_at, wc, wd, 0, (s / 2 + 3) % 16);
            end
        end
    endtask

    initial begin
        int cyc_cnt = 0;
        while (!done) begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 16; i++) begin m_up[i] = 8'hFF; m_stg[i] = 8'hFF; m_act[i] = 8'hFF; end
        m_cnt = 0; m_ovf = 0; m_seen = 0; m_armed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R2: reset state, read every channel
        #1;
        check(irq == 0, "R2 irq", irq, 0);
        check(ovf == 0, "R2 ovf", ovf, 0);
        for (int c = 0; c < 16; c++) cyc(0, 0, 8'h00, 0, 0, 0, 0, c);
        cyc(1, 7, 8'hFF, 0, 0, 0, 0, 3);
        #1 check(tx_byte == 8'hFF, "R2 downstream", tx_byte, 8'hFF);

        // R3: learning frame, all channels differ from reset value
        for (int c = 0; c < 16; c++) fr_vals[c] = 8'h10 + 8'(c);
        run_frame(0, -1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 3);
        #1 check(irq == 0, "R3 no report while learning", irq, 0);
        check(up_rd_data == 8'h13, "R3 learned value", up_rd_data, 8'h13);

        // R1 R4: identical frame, even slots random, no change reported
        run_frame(0, -1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        #1 check(irq == 0, "R1 R4 equal values silent", irq, 0);

        // R4: change channels 2 and 5
        fr_vals[2] = 8'hA2; fr_vals[5] = 8'hA5;
        run_frame(0, -1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 2);
        #1 check(irq == 1 && chg_chan == 4'd2, "R4 first change", chg_chan, 2);
        check(up_rd_data == 8'hA2, "R4 stored updated", up_rd_data, 8'hA2);
        cyc(0, 0, 0, 0, 0, 0, 1, 5);
        cyc(0, 0, 0, 0, 0, 0, 1, 5);
        cyc(0, 0, 0, 0, 0, 0, 1, 5);
        #1 check(irq == 0, "R5 drained", irq, 0);

        // R8: mid-frame write, then write on the frame-start cycle
        run_frame(0, 3, 4, 8'hAA);
        run_frame(0, 0, 6, 8'hC6);
        run_frame(0, -1, 0, 0);
        check(m_act[4] == 8'hAA && m_act[6] == 8'hC6, "R8 model sanity", m_act[6], 8'hC6);

        // R6: all channels change without pops
        for (int c = 0; c < 16; c++) fr_vals[c] = 8'h50 + 8'(c);
        run_frame(0, -1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 15);
        #1 check(ovf == 1, "R6 overflow set", ovf, 1);
        check(up_rd_data == 8'h5F, "R6 memory still updated", up_rd_data, 8'h5F);
        for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0, 0, 1, i);
        #1 check(irq == 0 && ovf == 1, "R6 sticky after drain", ovf, 1);

        // random traffic
        for (int f = 0; f < 60; f++) run_frame(1, -1, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule